// File: doc/BRIEF.md
# Configuration Capability Chain Search Engine

This block looks up one capability in a device's configuration space by walking its linked chain of capability headers. A lookup is started with a one-cycle start pulse that carries a target ID and a list selector. The selector picks either the short chain that lives in the 256-byte space, or the long chain that lives in the 4 KB space. The block then fetches headers one dword at a time through a plain request/valid read port. It follows next pointers until one of three things happens: an ID matches, the chain ends, or the chain proves to be broken.

The two chains use different header layouts. In a short-chain header, byte 0 holds an 8-bit ID and byte 1 holds an 8-bit next pointer. The chain is entered through the pointer byte stored in the dword at 0x34. In a long-chain header, bits [15:0] hold a 16-bit ID, bits [19:16] hold a 4-bit version and bits [31:20] hold a 12-bit next pointer. That chain always begins at 0x100. A match in one chain never counts for the other.

A completed lookup reports found, bad-pointer or hop-limit. It also reports the byte offset of the matching header and, for long-chain hits, its version field. Hop limits stop a chain that loops back on itself from hanging the block.

Top module: `cap_chain_walker`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, rd_req_o, found_o, bad_ptr_o and loop_err_o are low, and cap_offset_o and cap_ver_o are zero.
- R2: A short-chain lookup (ext_sel_i = 0) first reads the dword at 0x34. It takes bits [7:0] of that dword as the first header pointer and clears the pointer's low two bits. Each short-chain header it then reads supplies the ID from bits [7:0] and the next pointer from bits [15:8], also with the low two bits cleared. Only target_id_i[7:0] takes part in the compare, so the upper byte of the target has no effect.
- R3: A long-chain lookup (ext_sel_i = 1) first reads the dword at 0x100. Each header supplies the ID from bits [15:0], the version from bits [19:16] and the next pointer from bits [31:20], with the low two bits of the pointer cleared. All 16 ID bits are compared.
- R4: A matching header ends the lookup with found_o = 1 and cap_offset_o equal to that header's byte address. cap_ver_o carries the version field for a long-chain hit and is 0 for a short-chain hit. At most one of found_o, bad_ptr_o and loop_err_o is high in any result.
- R5: A next pointer of zero ends the lookup as not found, with all three flags low and cap_offset_o = 0. A first long-chain header whose ID and next pointer are both zero ends the lookup as not found after that single read.
- R6: A nonzero next pointer below 0x40 in the short chain, or below 0x100 in the long chain, ends the lookup with bad_ptr_o = 1 and issues no further read.
- R7: If the chain does not end after 48 short-chain headers or 960 long-chain headers have been read, the lookup ends with loop_err_o = 1 instead of following the next pointer.
- R8: Every read is a single-cycle rd_req_o pulse with a dword-aligned rd_addr_o. At most one read is outstanding. The next request follows in the cycle after rd_valid_i.
- R9: busy_o rises in the cycle after an accepted start and stays high until the lookup ends. done_o is high for exactly one cycle, the cycle after the rd_valid_i of the final read, and busy_o is low in that cycle. The result outputs are valid while done_o is high and hold their values until the next result.
- R10: A start pulse that arrives while busy_o is high is ignored. The running lookup keeps its target, its list selector and its sequence of read addresses.
- R11: The two chains are searched independently. An ID that is present only in the short chain is reported as not found by a long-chain lookup for the same numeric value, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a lookup |
| ext_sel_i | input | 1 | 0 selects the short chain, 1 the long chain |
| target_id_i | input | 16 | Capability ID to find (short chain uses [7:0]) |
| rd_req_o | output | 1 | One-cycle dword read request |
| rd_addr_o | output | 12 | Byte address of the requested dword |
| rd_valid_i | input | 1 | Read data valid pulse |
| rd_data_i | input | 32 | Returned dword |
| busy_o | output | 1 | Lookup in progress |
| done_o | output | 1 | One-cycle result pulse |
| found_o | output | 1 | Matching header found |
| bad_ptr_o | output | 1 | Chain held an out-of-range pointer |
| loop_err_o | output | 1 | Hop limit reached |
| cap_offset_o | output | 12 | Byte offset of the matching header |
| cap_ver_o | output | 4 | Version field of a long-chain hit |

## Verification
Any corruption of the walk's internal state first shows up on the read port. A wrong pointer, a wrong field extraction or a mis-masked address produces a different rd_addr_o on the very next request, one cycle after the offending rd_valid_i. A wrong hop count or a wrong end condition shows up as one read too many or too few, or as done_o arriving a request early or late. The reference model predicts the whole address sequence and the busy/done timing, so a divergence is caught in the cycle it appears rather than only when the final result is compared.

// File: rtl/cw_pkg.sv
package cw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_st_e;

    localparam int unsigned CW_ADDR_W = 12;
    localparam int unsigned CW_DATA_W = 32;
    localparam int unsigned CW_ID_W   = 16;
    localparam int unsigned CW_VER_W  = 4;

    typedef struct packed {
        walk_st_e               st;
        logic                   ext;
        logic                   root;
        logic [CW_ID_W-1:0]     tgt;
        logic [CW_ADDR_W-1:0]   addr;
        logic                   done;
        logic                   found;
        logic                   bad;
        logic                   loop;
        logic [CW_ADDR_W-1:0]   off;
        logic [CW_VER_W-1:0]    ver;
    } walk_regs_t;

endpackage

// File: rtl/cw_hdr_fields.sv
module cw_hdr_fields
    import cw_pkg::*;
(
    input  logic [CW_DATA_W-1:0] data_i,
    input  logic                 ext_i,
    input  logic                 root_i,
    output logic [CW_ID_W-1:0]   id_o,
    output logic [CW_VER_W-1:0]  ver_o,
    output logic [CW_ADDR_W-1:0] next_o,
    output logic                 empty_o
);

    logic [CW_ADDR_W-1:0] raw_next;

    always_comb begin
        if (ext_i) begin
            id_o     = data_i[15:0];
            ver_o    = data_i[19:16];
            raw_next = data_i[31:20];
        end else begin
            id_o     = {8'h00, data_i[7:0]};
            ver_o    = '0;
            raw_next = root_i ? {4'h0, data_i[7:0]} : {4'h0, data_i[15:8]};
        end
        // Pointers are always forced onto a dword boundary
        next_o  = {raw_next[CW_ADDR_W-1:2], 2'b00};
        empty_o = ext_i && root_i && (data_i[15:0] == 16'h0000) && (data_i[31:20] == 12'h000);
    end

endmodule

// File: rtl/cw_ptr_class.sv
module cw_ptr_class
    import cw_pkg::*;
#(
    parameter logic [CW_ADDR_W-1:0] STD_FLOOR = 12'h040,
    parameter logic [CW_ADDR_W-1:0] EXT_FLOOR = 12'h100
) (
    input  logic [CW_ADDR_W-1:0] ptr_i,
    input  logic                 ext_i,
    output logic                 is_end_o,
    output logic                 is_bad_o
);

    logic [CW_ADDR_W-1:0] floor_sel;

    always_comb begin
        floor_sel = ext_i ? EXT_FLOOR : STD_FLOOR;
        is_end_o  = (ptr_i == '0);
        is_bad_o  = !is_end_o && (ptr_i < floor_sel);
    end

endmodule

// File: rtl/cw_hop_ctr.sv
module cw_hop_ctr #(
    parameter int unsigned STD_MAX = 48,
    parameter int unsigned EXT_MAX = 960,
    localparam int unsigned TOP_MAX = (STD_MAX > EXT_MAX) ? STD_MAX : EXT_MAX,
    localparam int unsigned HOP_W   = $clog2(TOP_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic load_ext_i,
    input  logic mode_ext_i,
    input  logic inc_i,
    output logic at_limit_o
);

    localparam logic [HOP_W-1:0] STD_LIM = HOP_W'(STD_MAX);
    localparam logic [HOP_W-1:0] EXT_LIM = HOP_W'(EXT_MAX);

    logic [HOP_W-1:0] cnt_d, cnt_q;
    logic [HOP_W-1:0] lim;

    always_comb begin
        lim   = mode_ext_i ? EXT_LIM : STD_LIM;
        cnt_d = cnt_q;
        if (load_i) begin
            // The long chain's first header is itself an entry
            cnt_d = load_ext_i ? HOP_W'(1) : '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
        at_limit_o = (cnt_q == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= EXT_LIM) || (cnt_q <= STD_LIM));

    // R7
    no_inc_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i) |-> !at_limit_o);

endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
    import cw_pkg::*;
#(
    parameter int unsigned          STD_HOP_MAX = 48,
    parameter int unsigned          EXT_HOP_MAX = 960,
    parameter logic [11:0]          STD_ROOT    = 12'h034,
    parameter logic [11:0]          EXT_ROOT    = 12'h100,
    parameter logic [11:0]          STD_FLOOR   = 12'h040,
    parameter logic [11:0]          EXT_FLOOR   = 12'h100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        ext_sel_i,
    input  logic [15:0] target_id_i,
    output logic        rd_req_o,
    output logic [11:0] rd_addr_o,
    input  logic        rd_valid_i,
    input  logic [31:0] rd_data_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        found_o,
    output logic        bad_ptr_o,
    output logic        loop_err_o,
    output logic [11:0] cap_offset_o,
    output logic [3:0]  cap_ver_o
);

    walk_regs_t r_d, r_q;

    logic [CW_ID_W-1:0]   fld_id;
    logic [CW_VER_W-1:0]  fld_ver;
    logic [CW_ADDR_W-1:0] fld_next;
    logic                 fld_empty;
    logic                 ptr_end, ptr_bad;
    logic                 hop_load, hop_inc, hop_at_limit;
    logic                 id_hit;

    cw_hdr_fields u_fields (
        .data_i  (rd_data_i),
        .ext_i   (r_q.ext),
        .root_i  (r_q.root),
        .id_o    (fld_id),
        .ver_o   (fld_ver),
        .next_o  (fld_next),
        .empty_o (fld_empty)
    );

    cw_ptr_class #(
        .STD_FLOOR (STD_FLOOR),
        .EXT_FLOOR (EXT_FLOOR)
    ) u_class (
        .ptr_i    (fld_next),
        .ext_i    (r_q.ext),
        .is_end_o (ptr_end),
        .is_bad_o (ptr_bad)
    );

    cw_hop_ctr #(
        .STD_MAX (STD_HOP_MAX),
        .EXT_MAX (EXT_HOP_MAX)
    ) u_hops (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (hop_load),
        .load_ext_i (ext_sel_i),
        .mode_ext_i (r_q.ext),
        .inc_i      (hop_inc),
        .at_limit_o (hop_at_limit)
    );

    always_comb begin
        id_hit = r_q.ext ? (fld_id == r_q.tgt)
                         : (fld_id[7:0] == r_q.tgt[7:0]);
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        hop_load = 1'b0;
        hop_inc  = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    hop_load = 1'b1;
                    r_d.st   = ST_ISSUE;
                    r_d.ext  = ext_sel_i;
                    r_d.tgt  = target_id_i;
                    r_d.addr = ext_sel_i ? EXT_ROOT : STD_ROOT;
                    r_d.root = 1'b1;
                end
            end
            ST_ISSUE: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_valid_i) begin
                    r_d.root = 1'b0;
                    if (!(!r_q.ext && r_q.root) && fld_empty) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.found = 1'b0;
                        r_d.bad   = 1'b0;
                        r_d.loop  = 1'b0;
                        r_d.off   = '0;
                        r_d.ver   = '0;
                    end else if (!(!r_q.ext && r_q.root) && id_hit) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.found = 1'b1;
                        r_d.bad   = 1'b0;
                        r_d.loop  = 1'b0;
                        r_d.off   = r_q.addr;
                        r_d.ver   = fld_ver;
                    end else if (ptr_end || ptr_bad || hop_at_limit) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.found = 1'b0;
                        r_d.bad   = !ptr_end && ptr_bad;
                        r_d.loop  = !ptr_end && !ptr_bad;
                        r_d.off   = '0;
                        r_d.ver   = '0;
                    end else begin
                        hop_inc  = 1'b1;
                        r_d.addr = fld_next;
                        r_d.st   = ST_ISSUE;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.ext   <= 1'b0;
            r_q.root  <= 1'b0;
            r_q.tgt   <= '0;
            r_q.addr  <= '0;
            r_q.done  <= 1'b0;
            r_q.found <= 1'b0;
            r_q.bad   <= 1'b0;
            r_q.loop  <= 1'b0;
            r_q.off   <= '0;
            r_q.ver   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o     = (r_q.st == ST_ISSUE);
    assign rd_addr_o    = r_q.addr;
    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign found_o      = r_q.found;
    assign bad_ptr_o    = r_q.bad;
    assign loop_err_o   = r_q.loop;
    assign cap_offset_o = r_q.off;
    assign cap_ver_o    = r_q.ver;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R8
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o[1:0] == 2'b00));

    // R6
    ext_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && r_q.ext) |-> (rd_addr_o >= EXT_FLOOR));

    // R4
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({found_o, bad_ptr_o, loop_err_o}) <= 1));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(r_q.tgt) && $stable(r_q.ext)));

endmodule

// File: tb/cap_chain_walker_tb_top.sv
module cap_chain_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        ext_sel_i;
    logic [15:0] target_id_i;
    logic        rd_req_o;
    logic [11:0] rd_addr_o;
    logic        rd_valid_i;
    logic [31:0] rd_data_i;
    logic        busy_o, done_o, found_o, bad_ptr_o, loop_err_o;
    logic [11:0] cap_offset_o;
    logic [3:0]  cap_ver_o;

    always #5 clk = ~clk;

    cap_chain_walker dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .ext_sel_i    (ext_sel_i),
        .target_id_i  (target_id_i),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .rd_valid_i   (rd_valid_i),
        .rd_data_i    (rd_data_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .found_o      (found_o),
        .bad_ptr_o    (bad_ptr_o),
        .loop_err_o   (loop_err_o),
        .cap_offset_o (cap_offset_o),
        .cap_ver_o    (cap_ver_o)
    );

    logic [31:0] mem [0:1023];
    int n_cmp = 0;
    int n_bad = 0;
    int lat   = 1;
    bit checking = 0;
    string tag = "R1";

    // reference model state
    int exp_q[$];
    bit m_busy = 0, m_done = 0;
    int m_left = 0;
    bit e_found, e_bad, e_loop;
    int e_off, e_ver;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void walk(bit ext, logic [15:0] tgt);
        int p, hops;
        logic [31:0] d;
        exp_q.delete();
        e_found = 0; e_bad = 0; e_loop = 0; e_off = 0; e_ver = 0;
        if (!ext) begin
            exp_q.push_back('h34);
            p = int'(mem['h34 >> 2][7:0]) & 'hFC;
            hops = 0;
            while (1) begin
                if (p == 0) return;
                if (p < 'h40) begin e_bad = 1; return; end
                if (hops == 48) begin e_loop = 1; return; end
                exp_q.push_back(p);
                hops++;
                d = mem[p >> 2];
                if (d[7:0] == tgt[7:0]) begin e_found = 1; e_off = p; return; end
                p = int'(d[15:8]) & 'hFC;
            end
        end else begin
            p = 'h100;
            exp_q.push_back(p);
            d = mem[p >> 2];
            hops = 1;
            if (d[15:0] == 16'h0 && d[31:20] == 12'h0) return;
            while (1) begin
                if (d[15:0] == tgt) begin
                    e_found = 1; e_off = p; e_ver = int'(d[19:16]); return;
                end
                p = int'(d[31:20]) & 'hFFC;
                if (p == 0) return;
                if (p < 'h100) begin e_bad = 1; return; end
                if (hops == 960) begin e_loop = 1; return; end
                exp_q.push_back(p);
                hops++;
                d = mem[p >> 2];
            end
        end
    endfunction

    // reference model, advanced on every rising edge with pre-edge values
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0; exp_q.delete();
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (rd_valid_i) begin
                    m_left--;
                    if (m_left == 0) begin m_busy = 0; m_done = 1; end
                end
            end else if (start_i) begin
                walk(ext_sel_i, target_id_i);
                m_busy = 1;
                m_left = exp_q.size();
            end
        end
    end

    // read responder with programmable latency
    bit pend = 0;
    int rcnt = 0;
    logic [11:0] paddr;
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_i <= 1'b0;
            rd_data_i  <= '0;
            pend = 0;
        end else begin
            rd_valid_i <= 1'b0;
            if (pend) begin
                if (rcnt == 0) begin
                    rd_valid_i <= 1'b1;
                    rd_data_i  <= mem[paddr[11:2]];
                    pend = 0;
                end else begin
                    rcnt--;
                end
            end
            if (rd_req_o) begin
                pend = 1; paddr = rd_addr_o; rcnt = lat;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && checking) begin
            chk("R9", "busy_o", int'(busy_o), int'(m_busy));
            chk("R9", "done_o", int'(done_o), int'(m_done));
            if (rd_req_o) begin
                if (exp_q.size() == 0) begin
                    chk("R8", "unexpected read addr", int'(rd_addr_o), -1);
                end else begin
                    chk("R8", "read addr", int'(rd_addr_o), exp_q.pop_front());
                end
            end
            if (m_done) begin
                chk(tag, "found_o", int'(found_o), int'(e_found));
                chk(tag, "bad_ptr_o", int'(bad_ptr_o), int'(e_bad));
                chk(tag, "loop_err_o", int'(loop_err_o), int'(e_loop));
                chk(tag, "cap_offset_o", int'(cap_offset_o), e_off);
                chk(tag, "cap_ver_o", int'(cap_ver_o), e_ver);
                chk("R8", "reads left at done", exp_q.size(), 0);
            end
        end
    end

    task automatic build_base();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem['h34 >> 2]  = 32'h0000_0041;
        mem['h40 >> 2]  = {16'h0, 8'h50, 8'h05};
        mem['h50 >> 2]  = {16'h0, 8'h63, 8'h10};
        mem['h60 >> 2]  = {16'h0, 8'h00, 8'h11};
        mem['h100 >> 2] = {12'h140, 4'h1, 16'h0001};
        mem['h140 >> 2] = {12'h182, 4'h2, 16'h0010};
        mem['h180 >> 2] = {12'h000, 4'h3, 16'h000B};
    endtask

    task automatic lookup(bit ext, logic [15:0] tgt, string t, int l, bit poke);
        int w;
        tag = t;
        lat = l;
        @(negedge clk);
        start_i = 1'b1; ext_sel_i = ext; target_id_i = tgt;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            // R10: a second start mid-walk must be ignored
            start_i = 1'b1; ext_sel_i = !ext; target_id_i = ~tgt;
            @(negedge clk);
            start_i = 1'b0;
        end
        w = 0;
        while (!done_o && w < 20000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 20000) chk(t, "lookup timeout", 0, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; ext_sel_i = 1'b0; target_id_i = '0;
        build_base();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy_o", int'(busy_o), 0);
        chk("R1", "done_o", int'(done_o), 0);
        chk("R1", "rd_req_o", int'(rd_req_o), 0);
        chk("R1", "flags", int'({found_o, bad_ptr_o, loop_err_o}), 0);
        chk("R1", "cap_offset_o", int'(cap_offset_o), 0);
        chk("R1", "cap_ver_o", int'(cap_ver_o), 0);
        checking = 1;

        lookup(1'b0, 16'h0011, "R2", 0, 0);   // short chain, last entry
        lookup(1'b0, 16'hFF10, "R2", 2, 0);   // upper target byte ignored
        lookup(1'b0, 16'h0022, "R5", 1, 0);   // short chain end, not found
        lookup(1'b1, 16'h0010, "R3", 1, 0);   // long chain hit with version
        lookup(1'b1, 16'h000B, "R4", 3, 0);   // masked pointer 0x182 -> 0x180
        lookup(1'b1, 16'h0011, "R11", 0, 0);  // present only in short chain
        lookup(1'b0, 16'h000B, "R11", 2, 0);  // present only in long chain
        lookup(1'b0, 16'h0005, "R10", 2, 1);  // start while busy
        lookup(1'b1, 16'h000B, "R10", 1, 1);

        mem['h60 >> 2] = {16'h0, 8'h20, 8'h11};
        lookup(1'b0, 16'h0077, "R6", 1, 0);   // short pointer below floor
        mem['h180 >> 2] = {12'h0C0, 4'h3, 16'h000B};
        lookup(1'b1, 16'h7777, "R6", 0, 0);   // long pointer below floor

        mem['h60 >> 2] = {16'h0, 8'h40, 8'h11};
        lookup(1'b0, 16'h0099, "R7", 0, 0);   // short loop
        mem['h180 >> 2] = {12'h100, 4'h3, 16'h000B};
        lookup(1'b1, 16'h7777, "R7", 0, 0);   // long loop

        mem['h34 >> 2] = 32'h0000_0000;
        lookup(1'b0, 16'h0011, "R5", 1, 0);   // empty short chain
        mem['h34 >> 2] = 32'h0000_0012;
        lookup(1'b0, 16'h0011, "R6", 1, 0);   // root pointer below floor
        mem['h100 >> 2] = 32'h0000_0000;
        lookup(1'b1, 16'h0000, "R5", 2, 0);   // empty long chain

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule